// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

A circular buffer that keeps in-flight instructions in program order between dispatch and commit. Each slot holds a program counter, the following program counter, a sequence number, a commit-ready flag and a squashed flag. Dispatch writes at most one instruction per cycle at the tail. Commit removes at most one per cycle from the head, and only when the head slot is commit-ready. Execution units report completion by slot number.

A squash request carries a target sequence number. The block does not flush the buffer in one cycle. A walker state machine (states `SQ_IDLE` and `SQ_WALK`) moves backward from the tail, handling at most `SQ_WIDTH` slots per cycle. Each slot it visits that does not hold the target is marked squashed and commit-ready, so that it later drains through normal commit. The walk ends on the slot holding the target, which is left untouched, or on the head slot. Transitions: `SQ_IDLE -> SQ_WALK` on an accepted request; `SQ_WALK -> SQ_IDLE` when a batch hits the target or the head; otherwise `SQ_WALK` holds. Dispatch and commit are frozen for the whole walk.

Top module: `rob_walkback`

## Requirements
- R1: After reset the buffer is empty: occupancy is 0, free_cnt is DEPTH, head_ready is 0 and squash_done is 1.
- R2: An insert (ins_valid) is accepted when the buffer is not full, no walk is active and no squash request is accepted in the same cycle. The n-th accepted insert since reset, counting from 0, goes to slot n mod DEPTH. From the next cycle it is the tail, with its ready and squashed flags clear, and occupancy has risen by one.
- R3: An insert while occupancy equals DEPTH is ignored and occupancy stays at DEPTH.
- R4: cmp_valid sets the commit-ready flag of slot cmp_slot. head_ready is 1 only when the buffer is not empty and the head slot is commit-ready, so it is 0 whenever the buffer is empty.
- R5: retire_en removes the head on the next edge only if head_ready is 1; otherwise it is ignored. An accepted insert and an accepted retire in the same cycle leave occupancy unchanged.
- R6: free_cnt always equals DEPTH minus occupancy.
- R7: sq_valid is accepted only when the buffer is not empty and no walk is active, and squash_done then reads 0 from the next cycle. A request while the buffer is empty, or while a walk is active, is ignored.
- R8: From the cycle after acceptance, each cycle handles up to SQ_WIDTH slots, starting at the tail and moving toward the head. A visited slot whose sequence number differs from the target becomes squashed and commit-ready. The walk stops at the slot whose sequence number equals the target, and that slot is not marked.
- R9: If the walk reaches the head slot without finding the target, the head slot is marked (unless it holds the target) and the walk ends.
- R10: squash_done returns to 1 on the same edge that marks the final batch. This happens ceil(k / SQ_WIDTH) edges after the accepting edge, where k is the number of slots compared, including the stopping slot.
- R11: Inserts and retires are ignored during the cycle a squash is accepted and for the whole walk.
- R12: head_pc, head_npc, head_seq and head_squashed show the head slot, and tail_pc and tail_seq show the most recently inserted slot still held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request at the tail |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_npc | input | PC_W | Next PC of the inserted instruction |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| cmp_valid | input | 1 | Completion report |
| cmp_slot | input | log2(DEPTH) | Slot that completed |
| retire_en | input | 1 | Retire the head if it is ready |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Target sequence number of the squash |
| head_ready | output | 1 | Head slot present and commit-ready |
| head_pc | output | PC_W | PC of the head slot |
| head_npc | output | PC_W | Next PC of the head slot |
| head_seq | output | SEQ_W | Sequence number of the head slot |
| head_squashed | output | 1 | Squashed flag of the head slot |
| tail_pc | output | PC_W | PC of the tail slot |
| tail_seq | output | SEQ_W | Sequence number of the tail slot |
| occupancy | output | log2(DEPTH)+1 | Slots in use |
| free_cnt | output | log2(DEPTH)+1 | Slots free |
| squash_done | output | 1 | 1 when no walk is pending |

## Verification
Inserts, retires, completions and squash acceptance become visible on the first clock edge after the inputs are presented, because every output comes from registered state. A walk's marks then show one batch per edge, starting one edge after acceptance. The bench drives inputs on the falling edge. A behavioural queue model updates on the rising edge from the same inputs, and every output is compared with the model on the following falling edge. Each result is therefore checked in exactly the cycle it is due, including each intermediate batch of a walk.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WALK = 1'b1
    } sq_state_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_ins,
    input  logic             do_ret,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [CNT_W-1:0] occupancy,
    output logic             full,
    output logic             empty
);
    // Pointers carry one wrap bit above the slot index.
    logic [IDX_W:0] wptr, rptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_ins) wptr <= wptr + (IDX_W+1)'(1);
            if (do_ret) rptr <= rptr + (IDX_W+1)'(1);
        end
    end

    always_comb begin
        wr_idx    = wptr[IDX_W-1:0];
        head_idx  = rptr[IDX_W-1:0];
        tail_idx  = wr_idx - IDX_W'(1);
        occupancy = wptr - rptr;
        full      = (occupancy == CNT_W'(DEPTH));
        empty     = (occupancy == '0);
    end
endmodule

// File: rtl/rob_squash_walker.sv
module rob_squash_walker
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SEQ_W    = 16,
    parameter int SQ_WIDTH = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [SEQ_W-1:0]            start_seq,
    input  logic [IDX_W-1:0]            start_cur,
    input  logic [IDX_W-1:0]            head_idx,
    input  logic [DEPTH-1:0][SEQ_W-1:0] seq_tab,
    output logic [DEPTH-1:0]            kill,
    output logic                        busy,
    output logic                        done
);
    sq_state_e        state, state_nxt;
    logic [SEQ_W-1:0] target;
    logic [IDX_W-1:0] cursor, step_cur;
    logic [DEPTH-1:0] visit_kill;
    logic             hit_end;

    // One batch: up to SQ_WIDTH slots from the cursor toward the head.
    always_comb begin
        step_cur   = cursor;
        hit_end    = 1'b0;
        visit_kill = '0;
        for (int k = 0; k < SQ_WIDTH; k++) begin
            if (!hit_end) begin
                if (seq_tab[step_cur] == target) begin
                    hit_end = 1'b1;
                end else begin
                    visit_kill[step_cur] = 1'b1;
                    if (step_cur == head_idx) hit_end = 1'b1;
                    else                      step_cur = step_cur - IDX_W'(1);
                end
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_IDLE: if (start)   state_nxt = SQ_WALK;
            SQ_WALK: if (hit_end) state_nxt = SQ_IDLE;
            default:              state_nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        busy = (state == SQ_WALK);
        kill = busy ? visit_kill : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target <= '0;
            cursor <= '0;
            done   <= 1'b1;
        end else if (start) begin
            target <= start_seq;
            cursor <= start_cur;
            done   <= 1'b0;
        end else if (busy) begin
            cursor <= step_cur;
            if (hit_end) done <= 1'b1;
        end
    end
endmodule

// File: rtl/rob_walkback.sv
module rob_walkback #(
    parameter int DEPTH    = 8,
    parameter int PC_W     = 32,
    parameter int SEQ_W    = 16,
    parameter int SQ_WIDTH = 2,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [PC_W-1:0]  ins_pc,
    input  logic [PC_W-1:0]  ins_npc,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_slot,
    input  logic             retire_en,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic             head_ready,
    output logic [PC_W-1:0]  head_pc,
    output logic [PC_W-1:0]  head_npc,
    output logic [SEQ_W-1:0] head_seq,
    output logic             head_squashed,
    output logic [PC_W-1:0]  tail_pc,
    output logic [SEQ_W-1:0] tail_seq,
    output logic [CNT_W-1:0] occupancy,
    output logic [CNT_W-1:0] free_cnt,
    output logic             squash_done
);
    logic [DEPTH-1:0][PC_W-1:0]  pc_q, npc_q;
    logic [DEPTH-1:0][SEQ_W-1:0] seq_q;
    logic [DEPTH-1:0]            rdy_q, sqd_q, kill;
    logic [IDX_W-1:0]            wr_idx, head_idx, tail_idx;
    logic                        full, empty, busy;
    logic                        sq_accept, freeze, do_ins, do_ret;

    assign sq_accept = sq_valid && !empty && !busy;
    assign freeze    = busy || sq_accept;
    assign do_ins    = ins_valid && !full && !freeze;
    assign do_ret    = retire_en && head_ready && !freeze;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_ins    (do_ins),
        .do_ret    (do_ret),
        .wr_idx    (wr_idx),
        .head_idx  (head_idx),
        .tail_idx  (tail_idx),
        .occupancy (occupancy),
        .full      (full),
        .empty     (empty)
    );

    rob_squash_walker #(
        .DEPTH    (DEPTH),
        .SEQ_W    (SEQ_W),
        .SQ_WIDTH (SQ_WIDTH)
    ) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sq_accept),
        .start_seq (sq_seq),
        .start_cur (tail_idx),
        .head_idx  (head_idx),
        .seq_tab   (seq_q),
        .kill      (kill),
        .busy      (busy),
        .done      (squash_done)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_q[i]  <= '0;
                npc_q[i] <= '0;
                seq_q[i] <= '0;
                rdy_q[i] <= 1'b0;
                sqd_q[i] <= 1'b0;
            end else if (do_ins && wr_idx == IDX_W'(i)) begin
                pc_q[i]  <= ins_pc;
                npc_q[i] <= ins_npc;
                seq_q[i] <= ins_seq;
                rdy_q[i] <= 1'b0;
                sqd_q[i] <= 1'b0;
            end else begin
                if (kill[i]) begin
                    rdy_q[i] <= 1'b1;
                    sqd_q[i] <= 1'b1;
                end
                if (cmp_valid && cmp_slot == IDX_W'(i)) rdy_q[i] <= 1'b1;
            end
        end
    end

    always_comb begin
        head_ready    = !empty && rdy_q[head_idx];
        head_pc       = pc_q[head_idx];
        head_npc      = npc_q[head_idx];
        head_seq      = seq_q[head_idx];
        head_squashed = sqd_q[head_idx];
        tail_pc       = pc_q[tail_idx];
        tail_seq      = seq_q[tail_idx];
        free_cnt      = CNT_W'(DEPTH) - occupancy;
    end
endmodule

module rob_walkback_sva #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_valid,
    input logic             retire_en,
    input logic             sq_valid,
    input logic             head_ready,
    input logic [CNT_W-1:0] occupancy,
    input logic [CNT_W-1:0] free_cnt,
    input logic             squash_done
);
    // R3: occupancy never exceeds the slot count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    // R4: nothing is ready when empty
    a_r4_empty_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == '0 |-> !head_ready);

    // R11: no occupancy change while a walk is pending
    a_r11_walk_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !squash_done |=> occupancy == $past(occupancy));

    // R7: a walk only begins on a request against a non-empty buffer
    a_r7_start_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(squash_done) |-> ($past(sq_valid) && $past(occupancy) != '0));

    // R2: a lone accepted insert grows occupancy by one
    a_r2_insert_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_done && !sq_valid && ins_valid && free_cnt != '0 && !(retire_en && head_ready))
        |=> occupancy == $past(occupancy) + CNT_W'(1));

    // R5: a lone accepted retire shrinks occupancy by one
    a_r5_retire_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_done && !sq_valid && !ins_valid && retire_en && head_ready)
        |=> occupancy == $past(occupancy) - CNT_W'(1));
endmodule

bind rob_walkback rob_walkback_sva #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .retire_en   (retire_en),
    .sq_valid    (sq_valid),
    .head_ready  (head_ready),
    .occupancy   (occupancy),
    .free_cnt    (free_cnt),
    .squash_done (squash_done)
);

// File: tb/rob_walkback_tb.sv
`timescale 1ns/1ps
module rob_walkback_tb;
    localparam int DEPTH = 8;
    localparam int PC_W  = 32;
    localparam int SEQ_W = 16;
    localparam int SQW   = 2;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ins_valid = 0, cmp_valid = 0, retire_en = 0, sq_valid = 0;
    logic [PC_W-1:0]  ins_pc = '0, ins_npc = '0;
    logic [SEQ_W-1:0] ins_seq = '0, sq_seq = '0;
    logic [IDX_W-1:0] cmp_slot = '0;
    logic             head_ready, head_squashed, squash_done;
    logic [PC_W-1:0]  head_pc, head_npc, tail_pc;
    logic [SEQ_W-1:0] head_seq, tail_seq;
    logic [CNT_W-1:0] occupancy, free_cnt;

    always #4 clk = ~clk;

    rob_walkback #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W), .SQ_WIDTH(SQW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pc(ins_pc),
        .ins_npc(ins_npc), .ins_seq(ins_seq), .cmp_valid(cmp_valid),
        .cmp_slot(cmp_slot), .retire_en(retire_en), .sq_valid(sq_valid),
        .sq_seq(sq_seq), .head_ready(head_ready), .head_pc(head_pc),
        .head_npc(head_npc), .head_seq(head_seq), .head_squashed(head_squashed),
        .tail_pc(tail_pc), .tail_seq(tail_seq), .occupancy(occupancy),
        .free_cnt(free_cnt), .squash_done(squash_done)
    );

    typedef struct {
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  npc;
        logic [SEQ_W-1:0] seq;
        bit               rdy;
        bit               sqd;
    } ment_t;

    ment_t mq[$];
    bit    m_walk = 0, m_done = 1, checking = 0;
    int    m_cur = 0, m_base = 0;
    logic [SEQ_W-1:0] m_tgt = '0;
    int    n_vec = 0, n_bad = 0, cyc = 0;
    logic [SEQ_W-1:0] next_seq = 16'd100;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit acc, ret, ins, stop;
        int p;
        cyc++;
        if (!rst_n) begin
            mq.delete(); m_walk = 0; m_done = 1; m_base = 0;
        end else begin
            acc = !m_walk && sq_valid && mq.size() > 0;
            ret = !m_walk && !acc && retire_en && mq.size() > 0 && mq[0].rdy;
            ins = !m_walk && !acc && ins_valid && mq.size() < DEPTH;
            if (cmp_valid) begin
                p = (int'(cmp_slot) - m_base + DEPTH) % DEPTH;
                if (p < mq.size()) mq[p].rdy = 1;
            end
            if (m_walk) begin
                stop = 0;
                for (int k = 0; k < SQW; k++) begin
                    if (!stop) begin
                        if (mq[m_cur].seq == m_tgt) stop = 1;
                        else begin
                            mq[m_cur].sqd = 1; mq[m_cur].rdy = 1;
                            if (m_cur == 0) stop = 1; else m_cur--;
                        end
                    end
                end
                if (stop) begin m_walk = 0; m_done = 1; end
            end else begin
                if (ret) begin void'(mq.pop_front()); m_base = (m_base + 1) % DEPTH; end
                if (ins) mq.push_back('{ins_pc, ins_npc, ins_seq, 1'b0, 1'b0});
                if (acc) begin m_walk = 1; m_done = 0; m_cur = mq.size() - 1; m_tgt = sq_seq; end
            end
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            chk("R2 R3 R5 R11 occupancy", occupancy, mq.size());
            chk("R6 free_cnt", free_cnt, DEPTH - mq.size());
            chk("R4 head_ready", head_ready, (mq.size() > 0) ? mq[0].rdy : 0);
            chk("R7 R10 squash_done", squash_done, m_done);
            if (mq.size() > 0) begin
                chk("R12 head_pc", head_pc, mq[0].pc);
                chk("R12 head_npc", head_npc, mq[0].npc);
                chk("R12 head_seq", head_seq, mq[0].seq);
                chk("R8 R9 head_squashed", head_squashed, mq[0].sqd);
                chk("R12 tail_pc", tail_pc, mq[mq.size()-1].pc);
                chk("R12 tail_seq", tail_seq, mq[mq.size()-1].seq);
            end
        end
    end

    task automatic clear_in();
        ins_valid = 0; cmp_valid = 0; retire_en = 0; sq_valid = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_ins();
        ins_valid = 1; ins_seq = next_seq;
        ins_pc = 32'h1000 + {16'd0, next_seq} * 4; ins_npc = ins_pc + 4;
        next_seq++;
        step();
    endtask

    task automatic do_cmp(input int slot);
        cmp_valid = 1; cmp_slot = IDX_W'(slot); step();
    endtask

    task automatic do_ret();
        retire_en = 1; step();
    endtask

    task automatic do_sq(input logic [SEQ_W-1:0] t);
        sq_valid = 1; sq_seq = t; step();
    endtask

    task automatic wait_walk();
        for (int i = 0; i < 2 * DEPTH && !squash_done; i++) step();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int ins_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 occupancy", occupancy, 0);
        chk("R1 free_cnt", free_cnt, DEPTH);
        chk("R1 head_ready", head_ready, 0);
        chk("R1 squash_done", squash_done, 1);
        rst_n = 1; checking = 1;
        step();
        // R7: squash on empty is ignored
        do_sq(16'd5);
        chk("R7 empty squash ignored", squash_done, 1);
        // R2: inserts land in slots 0..4
        for (int i = 0; i < 5; i++) do_ins();
        // R5: retire of a non-ready head is ignored
        do_ret();
        chk("R5 not-ready retire ignored", occupancy, 5);
        // R4: complete slots 1 and 0, then retire two
        do_cmp(1); do_cmp(0);
        do_ret(); do_ret();
        chk("R5 two retired", occupancy, 3);
        // R3: fill to full, extra insert ignored
        for (int i = 0; i < 5; i++) do_ins();
        chk("R3 full", occupancy, DEPTH);
        do_ins();
        chk("R3 insert on full ignored", occupancy, DEPTH);
        // R8 R10: squash to a middle entry (head seq 102, tail 109; target 105)
        do_sq(16'd105);
        chk("R10 walk started", squash_done, 0);
        do_ins(); // R11: ignored during walk
        wait_walk();
        chk("R11 no insert during walk", occupancy, DEPTH);
        // R9: target older than every entry walks to the head
        do_sq(16'd1);
        wait_walk();
        chk("R9 head squashed", head_squashed, 1);
        // drain everything
        for (int i = 0; i < DEPTH; i++) do_ret();
        chk("R5 drained", occupancy, 0);
        // R8: target equals the tail, nothing marked
        do_ins(); do_ins();
        do_sq(next_seq - 1);
        wait_walk();
        chk("R8 tail target unmarked", head_squashed, 0);
        // R5: insert and retire in one cycle
        do_cmp((m_base) % DEPTH);
        ins_valid = 1; ins_seq = next_seq; ins_pc = 32'hABC0; ins_npc = 32'hABC4;
        next_seq++; retire_en = 1; step();
        chk("R5 net zero", occupancy, 2);
        // random traffic
        ins_cnt = 0;
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 1) == 1) begin
                ins_valid = 1; ins_seq = next_seq;
                ins_pc = $urandom; ins_npc = $urandom; next_seq++;
            end
            if (mq.size() > 0 && $urandom_range(0, 9) < 4) begin
                cmp_valid = 1;
                cmp_slot = IDX_W'((m_base + $urandom_range(0, mq.size() - 1)) % DEPTH);
            end
            if ($urandom_range(0, 1) == 1) retire_en = 1;
            if ($urandom_range(0, 19) == 0) begin
                sq_valid = 1;
                if (mq.size() > 0 && $urandom_range(0, 3) != 0)
                    sq_seq = mq[$urandom_range(0, mq.size() - 1)].seq;
                else
                    sq_seq = 16'd3;
            end
            step();
            ins_cnt++;
        end
        step();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule